// File: doc/BRIEF.md
# I2C Status and Mode Control Register

This block holds the status and mode state of an I2C controller and keeps it consistent with what happens on the bus. It owns the master/slave select, the transmit/receive direction, the bus-busy flag, the SCL-hold flag and four read-only event flags, and shows them as one 8-bit status word. A CPU writes the word through a one-cycle write strobe. A separate bus monitor and shifter report line events as single-cycle strobes, with a few value inputs that are sampled alongside them. Every bit is registered, and each one is updated from those writes and strobes by fixed priority rules.

Software starts a transfer by writing ones to the master, direction and busy bits in one write. This START request is granted only when the bus is seen idle. A guard window opens on every rising edge of the busy flag and stays open until the slave address has been received or a STOP is seen. While it is open, software cannot turn the mode bits on, so a START from another master that wins the race cannot be overwritten. Byte completion holds SCL low through the hold flag and pulses an interrupt request.

Status word, bit 7 down to 0: MST (master), TRX (transmit), BB (busy), PIN (SCL released), AL (arbitration lost), AAS (address matched), AD0 (general call), LRB (last received bit).

Top module: `i2c_status_ctrl`

## Requirements
- R1: Reset returns status to 0x10 (only PIN set) and irq to 0. The reset is asynchronous and active low.
- R2: A write with bits 7, 6 and 5 all set while BB is 0, with no START and no STOP strobe in that cycle, sets MST, TRX and BB on the next cycle.
- R3: A write with bit 5 set is a START request. If BB is already 1, or a START or STOP strobe arrives in the same cycle, the MST and TRX fields of that write are discarded.
- R4: From a rising edge of BB until an address-done strobe or a STOP strobe, writes of 1 to MST or TRX are ignored and writes of 0 take effect.
- R5: A START strobe sets BB and a STOP strobe clears it. STOP beats START and a granted request in the same cycle, and a STOP also clears MST and TRX.
- R6: An address-done strobe with received R/W bit 1, address-disable input 0 and MST 0 sets TRX. With address-disable at 1, or with MST at 1, TRX is left alone.
- R7: TRX clears on arbitration loss, on STOP, on START while MST is 0, or on a missing ACK while MST is 0. A clear beats a set in the same cycle.
- R8: Arbitration loss leaves MST unchanged until the next byte-done strobe, and MST clears on that strobe.
- R9: A byte-done strobe clears PIN. PIN returns to 1 on a status write with bit 4 set or on a data-register write strobe, and a byte-done in the same cycle wins. A write of 0 to bit 4 has no effect.
- R10: irq is high for exactly the one cycle in which PIN first reads 0 after a byte-done. It stays low if PIN was already 0.
- R11: Bits 3..0 ignore writes. AL is set by arbitration loss and cleared by START. AAS and AD0 load the match and general-call inputs on address-done and clear on START or STOP. LRB loads the last-bit input on byte-done.
- R12: A write with bit 5 clear loads MST and TRX from bits 7 and 6 (subject to R4) and leaves BB unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Status-word write strobe |
| wr_data | input | 8 | Status-word write value |
| dat_wr | input | 1 | Data-register write strobe (releases SCL) |
| als | input | 1 | Address-disable control |
| ev_start | input | 1 | START condition detected |
| ev_stop | input | 1 | STOP condition detected |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_byte_done | input | 1 | Byte transfer complete |
| ev_addr_done | input | 1 | Slave address reception complete |
| ev_addr_match | input | 1 | Address matched, valid with ev_addr_done |
| ev_gen_call | input | 1 | General call, valid with ev_addr_done |
| ev_rw_bit | input | 1 | Received R/W bit, valid with ev_addr_done |
| ev_ack_miss | input | 1 | ACK not returned |
| ev_last_bit | input | 1 | Last received bit, valid with ev_byte_done |
| status | output | 8 | Status word {MST,TRX,BB,PIN,AL,AAS,AD0,LRB} |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets same-cycle collisions. A STOP arriving with a START and a START request must leave the bus idle, and a design that ranks the set first would report a phantom busy bus. A START request that meets a foreign START strobe must be dropped, otherwise two masters would both believe they own the bus. TRX is driven by an arbitration loss and a matching address-done together, and a design that lets the set win would drive SDA after losing. The bench also checks that MST survives arbitration loss until the byte ends, that guard-window writes of 1 are dropped while writes of 0 still take effect, and that no second interrupt pulse is raised while SCL is already held low.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;
  localparam int SR_W    = 8;
  localparam int POS_MST = 7;
  localparam int POS_TRX = 6;
  localparam int POS_BB  = 5;
  localparam int POS_PIN = 4;
  localparam int POS_AL  = 3;
  localparam int POS_AAS = 2;
  localparam int POS_AD0 = 1;
  localparam int POS_LRB = 0;
  localparam int N_CAP   = 2;  // address-phase capture flags (AAS, AD0)
endpackage

// File: rtl/i2c_sr_mode.sv
module i2c_sr_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_mst,
  input  logic wr_trx,
  input  logic wr_bb,
  input  logic start_grant,
  input  logic bb_rise,
  input  logic als,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ev_arb_lost,
  input  logic ev_byte_done,
  input  logic ev_addr_done,
  input  logic ev_rw_bit,
  input  logic ev_ack_miss,
  output logic mst_q,
  output logic trx_q
);
  logic guard_q, al_pend_q;
  logic plain_wr, mst_wr_ok, trx_wr_ok;
  logic trx_clr, trx_set, mst_drop;
  logic mst_d, trx_d, guard_d, al_pend_d;

  // a write with the busy bit clear is a plain mode write
  assign plain_wr  = wr_en & ~wr_bb;
  assign mst_wr_ok = plain_wr & (~wr_mst | ~guard_q);
  assign trx_wr_ok = plain_wr & (~wr_trx | ~guard_q);

  assign mst_drop = ev_byte_done & (al_pend_q | ev_arb_lost);
  assign trx_clr  = ev_arb_lost | ev_stop | ((ev_start | ev_ack_miss) & ~mst_q);
  assign trx_set  = ev_addr_done & ~als & ~mst_q & ev_rw_bit;

  always_comb begin
    mst_d = mst_q;
    if (ev_stop || mst_drop) mst_d = 1'b0;
    else if (start_grant)    mst_d = 1'b1;
    else if (mst_wr_ok)      mst_d = wr_mst;
  end

  always_comb begin
    trx_d = trx_q;
    if (trx_clr)                      trx_d = 1'b0;
    else if (trx_set || start_grant)  trx_d = 1'b1;
    else if (trx_wr_ok)               trx_d = wr_trx;
  end

  always_comb begin
    guard_d = guard_q;
    if (bb_rise)                      guard_d = 1'b1;
    else if (ev_addr_done || ev_stop) guard_d = 1'b0;
  end

  always_comb begin
    al_pend_d = al_pend_q;
    if (ev_stop || ev_byte_done) al_pend_d = 1'b0;
    else if (ev_arb_lost)        al_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q     <= 1'b0;
      trx_q     <= 1'b0;
      guard_q   <= 1'b0;
      al_pend_q <= 1'b0;
    end else begin
      mst_q     <= mst_d;
      trx_q     <= trx_d;
      guard_q   <= guard_d;
      al_pend_q <= al_pend_d;
    end
  end
endmodule

// File: rtl/i2c_sr_bus.sv
module i2c_sr_bus #(
  parameter logic PIN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic ev_byte_done,
  input  logic start_grant,
  input  logic pin_release,
  output logic bb_q,
  output logic bb_rise,
  output logic pin_q,
  output logic irq_q
);
  logic bb_d, pin_d;

  always_comb begin
    bb_d = bb_q;
    if (ev_stop)                       bb_d = 1'b0;
    else if (ev_start || start_grant)  bb_d = 1'b1;
  end

  assign bb_rise = bb_d & ~bb_q;

  always_comb begin
    pin_d = pin_q;
    if (ev_byte_done)     pin_d = 1'b0;
    else if (pin_release) pin_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_q  <= 1'b0;
      pin_q <= PIN_RST;
      irq_q <= 1'b0;
    end else begin
      bb_q  <= bb_d;
      pin_q <= pin_d;
      irq_q <= ev_byte_done & pin_q;
    end
  end
endmodule

// File: rtl/i2c_sr_flags.sv
module i2c_sr_flags
  import i2c_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_arb_lost,
  input  logic             ev_byte_done,
  input  logic             ev_addr_done,
  input  logic [N_CAP-1:0] cap_val,
  input  logic             ev_last_bit,
  output logic             al_q,
  output logic [N_CAP-1:0] cap_q,
  output logic             lrb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           al_q <= 1'b0;
    else if (ev_arb_lost) al_q <= 1'b1;
    else if (ev_start)    al_q <= 1'b0;
  end

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cap_q[g] <= 1'b0;
      else if (ev_addr_done)        cap_q[g] <= cap_val[g];
      else if (ev_start || ev_stop) cap_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lrb_q <= 1'b0;
    else if (ev_byte_done) lrb_q <= ev_last_bit;
  end
endmodule

// File: rtl/i2c_status_ctrl.sv
module i2c_status_ctrl
  import i2c_sr_pkg::*;
#(
  parameter logic PIN_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_data,
  input  logic            dat_wr,
  input  logic            als,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            ev_arb_lost,
  input  logic            ev_byte_done,
  input  logic            ev_addr_done,
  input  logic            ev_addr_match,
  input  logic            ev_gen_call,
  input  logic            ev_rw_bit,
  input  logic            ev_ack_miss,
  input  logic            ev_last_bit,
  output logic [SR_W-1:0] status,
  output logic            irq
);
  logic mst_q, trx_q, bb_q, bb_rise, pin_q, al_q, lrb_q;
  logic [N_CAP-1:0] cap_q;
  logic start_req, start_grant, pin_release;
  logic unused_ro_bits;

  // the read-only positions of a write are discarded
  assign unused_ro_bits = ^wr_data[POS_AL:POS_LRB];

  assign start_req   = wr_en & wr_data[POS_BB];
  assign start_grant = start_req & wr_data[POS_MST] & wr_data[POS_TRX]
                     & ~bb_q & ~ev_start & ~ev_stop;
  assign pin_release = (wr_en & wr_data[POS_PIN]) | dat_wr;

  i2c_sr_mode u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_mst(wr_data[POS_MST]), .wr_trx(wr_data[POS_TRX]),
    .wr_bb(wr_data[POS_BB]), .start_grant(start_grant), .bb_rise(bb_rise),
    .als(als), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_arb_lost(ev_arb_lost), .ev_byte_done(ev_byte_done),
    .ev_addr_done(ev_addr_done), .ev_rw_bit(ev_rw_bit),
    .ev_ack_miss(ev_ack_miss), .mst_q(mst_q), .trx_q(trx_q)
  );

  i2c_sr_bus #(.PIN_RST(PIN_RST)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_done(ev_byte_done),
    .start_grant(start_grant), .pin_release(pin_release),
    .bb_q(bb_q), .bb_rise(bb_rise), .pin_q(pin_q), .irq_q(irq)
  );

  i2c_sr_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
    .ev_byte_done(ev_byte_done), .ev_addr_done(ev_addr_done),
    .cap_val({ev_addr_match, ev_gen_call}), .ev_last_bit(ev_last_bit),
    .al_q(al_q), .cap_q(cap_q), .lrb_q(lrb_q)
  );

  always_comb begin
    status          = '0;
    status[POS_MST] = mst_q;
    status[POS_TRX] = trx_q;
    status[POS_BB]  = bb_q;
    status[POS_PIN] = pin_q;
    status[POS_AL]  = al_q;
    status[POS_AAS] = cap_q[1];
    status[POS_AD0] = cap_q[0];
    status[POS_LRB] = lrb_q;
  end
endmodule

// File: rtl/i2c_sr_chk.sv
module i2c_sr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_arb_lost,
  input logic       ev_byte_done,
  input logic       ev_addr_done,
  input logic       ev_last_bit,
  input logic [7:0] status,
  input logic       irq
);
  AST_STOP_IDLES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> status[7:5] == 3'b000); // R5

  AST_TRX_DROP_ON_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> !status[6]); // R7

  AST_MST_HELD_AFTER_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_lost && !ev_byte_done && !ev_stop && status[7]) |=> status[7]); // R8

  AST_BYTE_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_done |=> (!status[4] && status[0] == $past(ev_last_bit))); // R9

  AST_IRQ_ON_PIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!status[4] && $past(status[4]))); // R10

  AST_RO_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_arb_lost && !ev_start && !ev_stop && !ev_addr_done && !ev_byte_done)
      |=> $stable(status[3:0])); // R11
endmodule

bind i2c_status_ctrl i2c_sr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .ev_start(ev_start), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
  .ev_byte_done(ev_byte_done), .ev_addr_done(ev_addr_done),
  .ev_last_bit(ev_last_bit), .status(status), .irq(irq)
);

// File: tb/i2c_status_ctrl_tb_top.sv
module i2c_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // event vector bit order: start stop arb byte addr match gcall rw ackmiss lastbit
  localparam logic [9:0] E_STA = 10'h200, E_STP = 10'h100, E_ARB = 10'h080,
                         E_BYT = 10'h040, E_ADR = 10'h020, E_MAT = 10'h010,
                         E_GCA = 10'h008, E_RW  = 10'h004, E_ACK = 10'h002,
                         E_LB  = 10'h001;

  typedef struct packed {
    logic       we;
    logic [7:0] wd;
    logic       dw;
    logic       al;
    logic [9:0] ev;
    logic [7:0] xs;
    logic       xi;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hE0, 1'b0, 1'b0, 10'h000,               8'hF0, 1'b0, 4'd2 },  // R2 start granted
    '{1'b0, 8'h00, 1'b0, 1'b0, E_STA,                 8'hF0, 1'b0, 4'd5 },  // R5 own start seen
    '{1'b0, 8'h00, 1'b0, 1'b0, E_BYT|E_LB,            8'hE1, 1'b1, 4'd10},  // R10 pin falls, irq
    '{1'b0, 8'h00, 1'b1, 1'b0, 10'h000,               8'hF1, 1'b0, 4'd9 },  // R9 data write releases
    '{1'b0, 8'h00, 1'b0, 1'b0, E_ARB,                 8'hB9, 1'b0, 4'd8 },  // R8 MST kept, AL set
    '{1'b0, 8'h00, 1'b0, 1'b0, E_BYT,                 8'h28, 1'b1, 4'd8 },  // R8 MST drops at byte end
    '{1'b0, 8'h00, 1'b0, 1'b0, E_BYT|E_LB,            8'h29, 1'b0, 4'd10},  // R10 no second pulse
    '{1'b0, 8'h00, 1'b0, 1'b0, E_STP,                 8'h09, 1'b0, 4'd5 },  // R5 stop
    '{1'b0, 8'h00, 1'b0, 1'b0, E_STA,                 8'h21, 1'b0, 4'd5 },  // R5 foreign start
    '{1'b1, 8'hCF, 1'b0, 1'b0, 10'h000,               8'h21, 1'b0, 4'd4 },  // R4 guarded ones dropped
    '{1'b0, 8'h00, 1'b0, 1'b0, E_ADR|E_MAT|E_GCA|E_RW,8'h67, 1'b0, 4'd6 },  // R6 slave transmit
    '{1'b1, 8'h10, 1'b0, 1'b0, 10'h000,               8'h37, 1'b0, 4'd12},  // R12 plain write
    '{1'b1, 8'h40, 1'b0, 1'b0, 10'h000,               8'h77, 1'b0, 4'd12},  // R12 TRX loaded
    '{1'b0, 8'h00, 1'b0, 1'b0, E_ACK,                 8'h37, 1'b0, 4'd7 },  // R7 ack miss as slave
    '{1'b1, 8'hE0, 1'b0, 1'b0, 10'h000,               8'h37, 1'b0, 4'd3 },  // R3 request with bus busy
    '{1'b1, 8'hE0, 1'b0, 1'b0, E_STP|E_STA,           8'h11, 1'b0, 4'd5 },  // R5 stop wins
    '{1'b1, 8'hE0, 1'b0, 1'b0, E_STA,                 8'h31, 1'b0, 4'd3 },  // R3 collides with start
    '{1'b0, 8'h00, 1'b0, 1'b1, E_ADR|E_MAT|E_RW,      8'h35, 1'b0, 4'd6 },  // R6 als blocks set
    '{1'b0, 8'h00, 1'b0, 1'b0, E_STP,                 8'h11, 1'b0, 4'd11},  // R11 stop clears AAS
    '{1'b0, 8'h00, 1'b0, 1'b0, E_ADR|E_RW|E_ARB,      8'h19, 1'b0, 4'd7 },  // R7 clear beats set
    '{1'b0, 8'h00, 1'b1, 1'b0, E_BYT,                 8'h08, 1'b1, 4'd9 },  // R9 hold beats release
    '{1'b1, 8'h1F, 1'b0, 1'b0, 10'h000,               8'h18, 1'b0, 4'd11}   // R11 low bits ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, dat_wr = 1'b0, als = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [9:0] ev = 10'h000;
  logic [7:0] status;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dat_wr(dat_wr), .als(als),
    .ev_start(ev[9]), .ev_stop(ev[8]), .ev_arb_lost(ev[7]),
    .ev_byte_done(ev[6]), .ev_addr_done(ev[5]), .ev_addr_match(ev[4]),
    .ev_gen_call(ev[3]), .ev_rw_bit(ev[2]), .ev_ack_miss(ev[1]),
    .ev_last_bit(ev[0]), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] xs, input logic xi);
    n_chk++;
    if (status !== xs || irq !== xi) begin
      n_bad++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", req, status, irq, xs, xi);
    end
  endtask

  // called just after a falling edge; holds inputs over one rising edge
  task automatic step(input logic we, input logic [7:0] wd, input logic dw,
                      input logic a, input logic [9:0] e);
    wr_en = we; wr_data = wd; dat_wr = dw; als = a; ev = e;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; dat_wr = 1'b0; als = 1'b0; ev = 10'h000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h10, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h10, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].wd, VEC[i].dw, VEC[i].al, VEC[i].ev);
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].xs, VEC[i].xi);
    end

    // R10 pulse, then R1 asynchronous reset mid-run
    step(1'b0, 8'h00, 1'b0, 1'b0, E_BYT);
    check("R10 pulse before reset", 8'h08, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 8'h10, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 guard window opened by a foreign start
    step(1'b0, 8'h00, 1'b0, 1'b0, E_STA);
    check("R5 start sets busy", 8'h30, 1'b0);
    step(1'b1, 8'h80, 1'b0, 1'b0, 10'h000);
    check("R4 MST one ignored", 8'h30, 1'b0);
    step(1'b1, 8'h40, 1'b0, 1'b0, 10'h000);
    check("R4 TRX one ignored", 8'h30, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, E_ADR);
    check("R4 address closes window", 8'h30, 1'b0);
    step(1'b1, 8'h90, 1'b0, 1'b0, 10'h000);
    check("R4 MST one accepted after window", 8'hB0, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 10'h000);
    check("R12 MST cleared by write", 8'h30, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, E_STP);
    check("R5 stop frees bus", 8'h10, 1'b0);
    step(1'b1, 8'hE0, 1'b0, 1'b0, 10'h000);
    check("R2 start granted again", 8'hF0, 1'b0);
    step(1'b1, 8'h10, 1'b0, 1'b0, 10'h000);
    check("R4 zero writes accepted in window", 8'h30, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule